// File: doc/BRIEF.md
# SD card data path controller

This block is the data-channel engine of an SD/SDIO host controller. It carries blocks of bytes between a transmit FIFO, a receive FIFO and the card data lines DAT[7:0]. The lane width is 1, 4 or 8 lines, chosen by a two-bit bus-mode field. A single six-state machine runs on the card clock. The states are idle, transmit-wait, send, busy, receive-wait and receive. Every bus value is launched and sampled on the rising edge.

Software-facing logic writes a control word: a write strobe, an enable bit, a direction bit and a block length in bytes. The block frames each block on every active line in this order: a start bit of 0, the payload, a 16-bit CRC for that line, and an end bit of 1. On transmit it generates the CRC and then waits out the card's busy signal. On receive it checks the CRC. Abnormal ends are reported as one-cycle pulses: CRC fail, receive timeout, transmit underrun and receive overrun.

Top module: `sd_data_path`

## Requirements
- R1: The bus-mode value fixes the lane use. 2'b01 puts one byte on DAT[3:0] over two cycles, with bits [7:4] in the first cycle and DAT[i] carrying bit 4+i, then bit i. 2'b10 puts a whole byte on DAT[7:0] in one cycle, with DAT[i] carrying bit i. 2'b00 and the reserved 2'b11 both send one byte on DAT0 alone over eight cycles, most significant bit first.
- R2: A transfer begins only when the control write strobe is sampled high with the enable bit set while the machine is idle. A write with the enable bit clear has no effect.
- R3: With direction 0, the machine waits with every output enable low and no FIFO pop until the transmit FIFO reports non-empty. It then pops the first byte.
- R4: A transmitted block drives each active line in four parts: one start bit 0, the payload per R1, 16 CRC bits (polynomial 0x1021, initial value 0, most significant bit first), then one end bit 1. Output enables are high only on active lanes, and only for these cycles.
- R5: After the end bit, the block releases all lines and waits while DAT0 is low. One cycle after DAT0 is sampled high, it pulses the done flag.
- R6: With direction 1, the block waits for a low level on DAT0. It then assembles the following bits per R1 and pushes each completed byte into the receive FIFO.
- R7: On receive, the block compares the 16 received CRC bits of every active lane with its own computed value. In the cycle after the end bit is sampled, it pulses crc_fail if any bit differed, otherwise done. At most one status flag is high in any cycle.
- R8: If no start bit arrives within tmo_limit cycles in receive-wait, the block pulses timeout in the cycle after the last of those cycles and returns to idle.
- R9: If the transmit FIFO is empty when the next payload byte is needed, the block pulses underrun, releases the lines and returns to idle.
- R10: If the receive FIFO is full when a byte completes, the block pushes nothing, pulses overrun and returns to idle.
- R11: After reset, all output enables, FIFO strobes and status flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_en_i | input | 1 | Data-enable bit of the control word |
| ctl_dir_i | input | 1 | Direction: 0 host to card, 1 card to host |
| ctl_len_i | input | LEN_W | Block length in bytes (1 or more) |
| bus_mode_i | input | 2 | Lane width select |
| tmo_limit_i | input | TMO_W | Receive-wait timeout in card clocks |
| tx_data_i | input | 8 | Head byte of the transmit FIFO |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_pop_o | output | 1 | Transmit FIFO pop strobe |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_data_o | output | 8 | Byte to push into the receive FIFO |
| rx_push_o | output | 1 | Receive FIFO push strobe |
| dat_i | input | 8 | Sampled card data lines |
| dat_o | output | 8 | Driven card data lines |
| dat_oe_o | output | 8 | Per-line output enables |
| done_o | output | 1 | Block completed pulse |
| crc_fail_o | output | 1 | Receive CRC mismatch pulse |
| timeout_o | output | 1 | Receive start-bit timeout pulse |
| underrun_o | output | 1 | Transmit FIFO underrun pulse |
| overrun_o | output | 1 | Receive FIFO overrun pulse |

## Verification
A fault in the slice or byte counters moves the CRC window. On transmit, this shows up within the same block as a wrong bit on some lane, found by comparing the frame cycle by cycle. On receive, it appears as a misassembled pushed byte or a wrong done/crc_fail choice one cycle after the end bit. A wrong next state shows up within a few cycles, for example as an enable during the wait or busy phases, a missing pop, or a flag pulse one cycle early or late.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT_S = 3'd1,
        ST_SEND   = 3'd2,
        ST_BUSY   = 3'd3,
        ST_WAIT_R = 3'd4,
        ST_RECV   = 3'd5
    } dp_state_e;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_DATA  = 2'd1,
        PH_CRC   = 2'd2,
        PH_END   = 2'd3
    } phase_e;

    localparam logic [1:0] BM_LANE1 = 2'b00;
    localparam logic [1:0] BM_LANE4 = 2'b01;
    localparam logic [1:0] BM_LANE8 = 2'b10;

endpackage

// File: rtl/sdp_crc16_lane.sv
module sdp_crc16_lane #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h1021
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic upd_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic msb_o
);
    logic [CRC_W-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        fb    = bit_i ^ crc_q[CRC_W-1];
        crc_d = crc_q;
        if (clr_i) begin
            crc_d = '0;
        end else if (upd_i) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
        end else if (shift_i) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) crc_q <= '0;
        else         crc_q <= crc_d;
    end

    assign msb_o = crc_q[CRC_W-1];

endmodule

// File: rtl/sdp_lane_map.sv
module sdp_lane_map
    import sdp_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic [7:0] sh_i,
    input  logic [7:0] dat_i,
    output logic [7:0] tx_bits_o,
    output logic [7:0] sh_shift_o,
    output logic [7:0] sh_fill_o,
    output logic [7:0] mask_o,
    output logic [2:0] last_slice_o
);
    always_comb begin
        case (mode_i)
            BM_LANE4: begin
                tx_bits_o    = {4'b0, sh_i[7:4]};
                sh_shift_o   = {sh_i[3:0], 4'b0};
                sh_fill_o    = {sh_i[3:0], dat_i[3:0]};
                mask_o       = 8'h0F;
                last_slice_o = 3'd1;
            end
            BM_LANE8: begin
                tx_bits_o    = sh_i;
                sh_shift_o   = 8'h00;
                sh_fill_o    = dat_i;
                mask_o       = 8'hFF;
                last_slice_o = 3'd0;
            end
            default: begin
                tx_bits_o    = {7'b0, sh_i[7]};
                sh_shift_o   = {sh_i[6:0], 1'b0};
                sh_fill_o    = {sh_i[6:0], dat_i[0]};
                mask_o       = 8'h01;
                last_slice_o = 3'd7;
            end
        endcase
    end

endmodule

// File: rtl/sd_data_path.sv
module sd_data_path
    import sdp_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int TMO_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_we_i,
    input  logic             ctl_en_i,
    input  logic             ctl_dir_i,
    input  logic [LEN_W-1:0] ctl_len_i,
    input  logic [1:0]       bus_mode_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic [7:0]       tx_data_i,
    input  logic             tx_empty_i,
    output logic             tx_pop_o,
    input  logic             rx_full_i,
    output logic [7:0]       rx_data_o,
    output logic             rx_push_o,
    input  logic [7:0]       dat_i,
    output logic [7:0]       dat_o,
    output logic [7:0]       dat_oe_o,
    output logic             done_o,
    output logic             crc_fail_o,
    output logic             timeout_o,
    output logic             underrun_o,
    output logic             overrun_o
);
    localparam int LANES = 8;
    localparam int CRC_W = 16;
    localparam int CC_W  = $clog2(CRC_W);
    localparam int SL_W  = $clog2(LANES);

    typedef struct packed {
        dp_state_e        st;
        phase_e           ph;
        logic [1:0]       mode;
        logic [LANES-1:0] sh;
        logic [LEN_W-1:0] bc;
        logic [SL_W-1:0]  sl;
        logic [CC_W-1:0]  cc;
        logic [TMO_W-1:0] tmo;
        logic             err;
        logic             fl_done;
        logic             fl_crc;
        logic             fl_tmo;
        logic             fl_urun;
        logic             fl_orun;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [LANES-1:0] tx_bits, sh_shift, sh_fill, lane_mask, crc_msb, crc_src;
    logic [SL_W-1:0]  last_slice;
    logic             crc_clr, crc_upd, crc_shift;
    logic             slice_last, byte_last, crc_last;

    sdp_lane_map u_map (
        .mode_i       (ctx_q.mode),
        .sh_i         (ctx_q.sh),
        .dat_i        (dat_i),
        .tx_bits_o    (tx_bits),
        .sh_shift_o   (sh_shift),
        .sh_fill_o    (sh_fill),
        .mask_o       (lane_mask),
        .last_slice_o (last_slice)
    );

    assign crc_src = (ctx_q.st == ST_SEND) ? tx_bits : dat_i;

    for (genvar g = 0; g < LANES; g++) begin : g_crc
        sdp_crc16_lane #(.CRC_W(CRC_W)) u_crc (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (crc_clr),
            .upd_i   (crc_upd),
            .shift_i (crc_shift),
            .bit_i   (crc_src[g]),
            .msb_o   (crc_msb[g])
        );
    end

    assign slice_last = (ctx_q.sl == last_slice);
    assign byte_last  = (ctx_q.bc == LEN_W'(1));
    assign crc_last   = (ctx_q.cc == CC_W'(CRC_W - 1));

    always_comb begin
        ctx_d         = ctx_q;
        ctx_d.fl_done = 1'b0;
        ctx_d.fl_crc  = 1'b0;
        ctx_d.fl_tmo  = 1'b0;
        ctx_d.fl_urun = 1'b0;
        ctx_d.fl_orun = 1'b0;
        tx_pop_o      = 1'b0;
        rx_push_o     = 1'b0;
        dat_o         = '0;
        dat_oe_o      = '0;
        crc_clr       = 1'b0;
        crc_upd       = 1'b0;
        crc_shift     = 1'b0;

        case (ctx_q.st)
            ST_IDLE: begin
                if (ctl_we_i && ctl_en_i) begin
                    ctx_d.mode = bus_mode_i;
                    ctx_d.bc   = ctl_len_i;
                    ctx_d.tmo  = '0;
                    ctx_d.st   = ctl_dir_i ? ST_WAIT_R : ST_WAIT_S;
                end
            end
            ST_WAIT_S: begin
                if (!tx_empty_i) begin
                    tx_pop_o = 1'b1;
                    crc_clr  = 1'b1;
                    ctx_d.sh = tx_data_i;
                    ctx_d.sl = '0;
                    ctx_d.ph = PH_START;
                    ctx_d.st = ST_SEND;
                end
            end
            ST_SEND: begin
                dat_oe_o = lane_mask;
                case (ctx_q.ph)
                    PH_START: begin
                        ctx_d.ph = PH_DATA;
                    end
                    PH_DATA: begin
                        dat_o   = tx_bits & lane_mask;
                        crc_upd = 1'b1;
                        if (!slice_last) begin
                            ctx_d.sl = ctx_q.sl + 1'b1;
                            ctx_d.sh = sh_shift;
                        end else if (byte_last) begin
                            ctx_d.ph = PH_CRC;
                            ctx_d.cc = '0;
                        end else if (tx_empty_i) begin
                            ctx_d.fl_urun = 1'b1;
                            ctx_d.st      = ST_IDLE;
                        end else begin
                            tx_pop_o = 1'b1;
                            ctx_d.sh = tx_data_i;
                            ctx_d.sl = '0;
                            ctx_d.bc = ctx_q.bc - 1'b1;
                        end
                    end
                    PH_CRC: begin
                        dat_o     = crc_msb & lane_mask;
                        crc_shift = 1'b1;
                        ctx_d.cc  = ctx_q.cc + 1'b1;
                        if (crc_last) ctx_d.ph = PH_END;
                    end
                    default: begin
                        dat_o    = lane_mask;
                        ctx_d.st = ST_BUSY;
                    end
                endcase
            end
            ST_BUSY: begin
                if (dat_i[0]) begin
                    ctx_d.fl_done = 1'b1;
                    ctx_d.st      = ST_IDLE;
                end
            end
            ST_WAIT_R: begin
                if (!dat_i[0]) begin
                    crc_clr   = 1'b1;
                    ctx_d.sl  = '0;
                    ctx_d.err = 1'b0;
                    ctx_d.ph  = PH_DATA;
                    ctx_d.st  = ST_RECV;
                end else if (({1'b0, ctx_q.tmo} + 1'b1) >= {1'b0, tmo_limit_i}) begin
                    ctx_d.fl_tmo = 1'b1;
                    ctx_d.st     = ST_IDLE;
                end else begin
                    ctx_d.tmo = ctx_q.tmo + 1'b1;
                end
            end
            ST_RECV: begin
                case (ctx_q.ph)
                    PH_DATA: begin
                        crc_upd  = 1'b1;
                        ctx_d.sh = sh_fill;
                        if (!slice_last) begin
                            ctx_d.sl = ctx_q.sl + 1'b1;
                        end else if (rx_full_i) begin
                            ctx_d.fl_orun = 1'b1;
                            ctx_d.st      = ST_IDLE;
                        end else begin
                            rx_push_o = 1'b1;
                            ctx_d.sl  = '0;
                            if (byte_last) begin
                                ctx_d.ph = PH_CRC;
                                ctx_d.cc = '0;
                            end else begin
                                ctx_d.bc = ctx_q.bc - 1'b1;
                            end
                        end
                    end
                    PH_CRC: begin
                        crc_shift = 1'b1;
                        ctx_d.err = ctx_q.err | (|((dat_i ^ crc_msb) & lane_mask));
                        ctx_d.cc  = ctx_q.cc + 1'b1;
                        if (crc_last) ctx_d.ph = PH_END;
                    end
                    default: begin
                        ctx_d.fl_crc  = ctx_q.err;
                        ctx_d.fl_done = !ctx_q.err;
                        ctx_d.st      = ST_IDLE;
                    end
                endcase
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctx_q <= '0;
        else         ctx_q <= ctx_d;
    end

    assign rx_data_o  = sh_fill;
    assign done_o     = ctx_q.fl_done;
    assign crc_fail_o = ctx_q.fl_crc;
    assign timeout_o  = ctx_q.fl_tmo;
    assign underrun_o = ctx_q.fl_urun;
    assign overrun_o  = ctx_q.fl_orun;

    a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.st == ST_IDLE && !(ctl_we_i && ctl_en_i)) |=> (ctx_q.st == ST_IDLE));

    a_r3_wait_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.st == ST_WAIT_S && tx_empty_i) |=> (ctx_q.st == ST_WAIT_S));

    a_r4_drive_only_in_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dat_oe_o != '0) |-> (ctx_q.st == ST_SEND));

    a_r7_single_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({done_o, crc_fail_o, timeout_o, underrun_o, overrun_o}));

    a_r8_timeout_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> ($past(ctx_q.st) == ST_WAIT_R && ctx_q.st == ST_IDLE));

    a_r9_underrun_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(underrun_o) |-> ($past(ctx_q.st) == ST_SEND && dat_oe_o == '0));

    a_r10_overrun_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(overrun_o) |-> ($past(ctx_q.st) == ST_RECV && $past(rx_full_i)));

endmodule

// File: tb/sd_data_path_tb.sv
`timescale 1ns/1ps
module sd_data_path_tb_top;
    localparam int LEN_W = 10;
    localparam int TMO_W = 16;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             ctl_we_i = 1'b0, ctl_en_i = 1'b0, ctl_dir_i = 1'b0;
    logic [LEN_W-1:0] ctl_len_i = '0;
    logic [1:0]       bus_mode_i = 2'b00;
    logic [TMO_W-1:0] tmo_limit_i = 16'd100;
    logic [7:0]       tx_data_i;
    logic             tx_empty_i, tx_pop_o;
    logic             rx_full_i = 1'b0;
    logic [7:0]       rx_data_o;
    logic             rx_push_o;
    logic [7:0]       dat_i = 8'hFF;
    logic [7:0]       dat_o, dat_oe_o;
    logic             done_o, crc_fail_o, timeout_o, underrun_o, overrun_o;

    always #4 clk_i = ~clk_i;

    sd_data_path #(.LEN_W(LEN_W), .TMO_W(TMO_W)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .ctl_we_i(ctl_we_i), .ctl_en_i(ctl_en_i),
        .ctl_dir_i(ctl_dir_i), .ctl_len_i(ctl_len_i), .bus_mode_i(bus_mode_i),
        .tmo_limit_i(tmo_limit_i), .tx_data_i(tx_data_i), .tx_empty_i(tx_empty_i),
        .tx_pop_o(tx_pop_o), .rx_full_i(rx_full_i), .rx_data_o(rx_data_o),
        .rx_push_o(rx_push_o), .dat_i(dat_i), .dat_o(dat_o), .dat_oe_o(dat_oe_o),
        .done_o(done_o), .crc_fail_o(crc_fail_o), .timeout_o(timeout_o),
        .underrun_o(underrun_o), .overrun_o(overrun_o)
    );

    // bench FIFO models
    logic [7:0] txq [4];
    logic [7:0] rxq [4];
    int pop_cnt = 0, push_cnt = 0, tx_base = 0, tx_cnt = 0, tx_idx;
    int done_cnt = 0, urun_cnt = 0, tmo_cnt = 0;
    assign tx_idx     = pop_cnt - tx_base;
    assign tx_empty_i = (tx_idx >= tx_cnt);
    assign tx_data_i  = txq[tx_idx[1:0]];

    always @(posedge clk_i) begin
        if (tx_pop_o) pop_cnt <= pop_cnt + 1;
        if (rx_push_o) begin
            rxq[push_cnt[1:0]] <= rx_data_o;
            push_cnt <= push_cnt + 1;
        end
        if (done_o)     done_cnt <= done_cnt + 1;
        if (underrun_o) urun_cnt <= urun_cnt + 1;
        if (timeout_o)  tmo_cnt  <= tmo_cnt + 1;
    end

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    int cyc = 0;
    always @(posedge clk_i) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0000);
    endfunction

    function automatic int lanes_of(input logic [1:0] m);
        return (m == 2'b01) ? 4 : (m == 2'b10) ? 8 : 1;
    endfunction

    // [23:22] mode, [21:20] len, [19:12] b0, [11:4] b1, [3] corrupt, [2:0] pre-wait
    localparam logic [23:0] VEC [6] = '{
        {2'b00, 2'd1, 8'hA5, 8'h00, 1'b0, 3'd0},
        {2'b01, 2'd2, 8'h3C, 8'h96, 1'b1, 3'd2},
        {2'b10, 2'd2, 8'hF0, 8'h0F, 1'b0, 3'd0},
        {2'b11, 2'd1, 8'h5A, 8'h00, 1'b0, 3'd3},
        {2'b10, 2'd1, 8'h81, 8'h00, 1'b1, 3'd1},
        {2'b01, 2'd1, 8'hE7, 8'h00, 1'b0, 3'd0}
    };

    logic [7:0] frm [40];
    int         frm_n;
    logic [7:0] mask;

    // build expected lane frame (start, data, crc, end) per R1/R4
    task automatic build_frame(input logic [1:0] m, input int len, input logic [7:0] b0, input logic [7:0] b1);
        int L, S;
        logic [15:0] crcs [8];
        logic [7:0] by;
        L = lanes_of(m); S = 8 / L;
        mask = 8'((1 << L) - 1);
        for (int i = 0; i < 8; i++) crcs[i] = 16'h0;
        frm_n = 0;
        frm[frm_n++] = 8'h00;
        for (int b = 0; b < len; b++) begin
            by = (b == 0) ? b0 : b1;
            for (int s = 0; s < S; s++) begin
                logic [7:0] v;
                v = 8'h00;
                for (int i = 0; i < L; i++) begin
                    v[i] = by[8 - L * (s + 1) + i];
                    crcs[i] = crc_step(crcs[i], v[i]);
                end
                frm[frm_n++] = v;
            end
        end
        for (int k = 0; k < 16; k++) begin
            logic [7:0] v;
            v = 8'h00;
            for (int i = 0; i < L; i++) v[i] = crcs[i][15 - k];
            frm[frm_n++] = v;
        end
        frm[frm_n++] = mask;
    endtask

    task automatic run_send(input logic [1:0] m, input int len, input logic [7:0] b0, input logic [7:0] b1, input int pre);
        int mism, pops0, dn0;
        logic [7:0] first_act, first_exp;
        build_frame(m, len, b0, b1);
        @(negedge clk_i);
        txq[0] = b0; txq[1] = b1;
        tx_base = pop_cnt; tx_cnt = 0; pops0 = pop_cnt;
        dat_i = 8'h00;
        ctl_we_i = 1; ctl_en_i = 1; ctl_dir_i = 0; bus_mode_i = m; ctl_len_i = LEN_W'(len);
        @(negedge clk_i);
        ctl_we_i = 0;
        for (int p = 0; p < pre; p++) begin
            chk(dat_oe_o == 8'h00 && !tx_pop_o, "R3 wait on empty fifo", {dat_oe_o, 7'b0, tx_pop_o}, 0);
            @(negedge clk_i);
        end
        tx_cnt = len;
        mism = 0; first_act = 0; first_exp = 0;
        for (int k = 0; k < frm_n; k++) begin
            @(negedge clk_i);
            if (dat_oe_o != mask || (dat_o & mask) != frm[k]) begin
                if (mism == 0) begin first_act = dat_o; first_exp = frm[k]; end
                mism++;
            end
        end
        chk(mism == 0, "R1/R4 transmit frame", first_act, first_exp);
        dn0 = done_cnt;
        for (int h = 0; h < 3; h++) begin
            @(negedge clk_i);
            chk(dat_oe_o == 8'h00 && !done_o, "R5 busy hold", {dat_oe_o, 7'b0, done_o}, 0);
        end
        dat_i = 8'hFF;
        @(negedge clk_i);
        chk(done_o == 1'b1, "R5 done after busy", done_o, 1);
        chk(pop_cnt - pops0 == len, "R3 pop count", pop_cnt - pops0, len);
        @(negedge clk_i);
    endtask

    task automatic run_recv(input logic [1:0] m, input int len, input logic [7:0] b0, input logic [7:0] b1, input bit corrupt);
        int push0;
        build_frame(m, len, b0, b1);
        @(negedge clk_i);
        dat_i = 8'hFF; rx_full_i = 0; push0 = push_cnt;
        ctl_we_i = 1; ctl_en_i = 1; ctl_dir_i = 1; bus_mode_i = m; ctl_len_i = LEN_W'(len);
        tmo_limit_i = 16'd100;
        @(negedge clk_i);
        ctl_we_i = 0;
        @(negedge clk_i);
        @(negedge clk_i);
        for (int k = 0; k < frm_n; k++) begin
            logic [7:0] v;
            v = frm[k];
            if (corrupt && k == frm_n - 5) v[0] = ~v[0];
            dat_i = v | ~mask;
            @(negedge clk_i);
        end
        dat_i = 8'hFF;
        chk(crc_fail_o == corrupt && done_o == !corrupt, "R7 crc verdict",
            {crc_fail_o, done_o}, {corrupt, !corrupt});
        chk(push_cnt - push0 == len, "R6 push count", push_cnt - push0, len);
        chk(rxq[push0[1:0]] == b0, "R6 first byte", rxq[push0[1:0]], b0);
        if (len > 1) begin
            int j;
            j = push0 + 1;
            chk(rxq[j[1:0]] == b1, "R6 second byte", rxq[j[1:0]], b1);
        end
        @(negedge clk_i);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R11 reset state
        chk(dat_oe_o == 0 && !tx_pop_o && !rx_push_o, "R11 reset outputs", {dat_oe_o, tx_pop_o, rx_push_o}, 0);
        chk({done_o, crc_fail_o, timeout_o, underrun_o, overrun_o} == 0, "R11 reset flags",
            {done_o, crc_fail_o, timeout_o, underrun_o, overrun_o}, 0);
        rst_ni = 1;
        @(negedge clk_i);

        for (int v = 0; v < 6; v++) begin
            logic [23:0] e;
            e = VEC[v];
            run_send(e[23:22], int'(e[21:20]), e[19:12], e[11:4], int'(e[2:0]));
            run_recv(e[23:22], int'(e[21:20]), e[19:12], e[11:4], e[3]);
        end

        // R2: write with enable clear is ignored
        begin
            int t0, p0;
            t0 = tmo_cnt; p0 = pop_cnt;
            dat_i = 8'hFF; tmo_limit_i = 16'd2;
            ctl_we_i = 1; ctl_en_i = 0; ctl_dir_i = 1;
            @(negedge clk_i);
            ctl_we_i = 0;
            ctl_dir_i = 0; tx_base = pop_cnt; tx_cnt = 1;
            ctl_we_i = 1;
            @(negedge clk_i);
            ctl_we_i = 0;
            repeat (8) @(negedge clk_i);
            chk(tmo_cnt == t0, "R2 ignored receive start", tmo_cnt - t0, 0);
            chk(pop_cnt == p0 && dat_oe_o == 0, "R2 ignored transmit start", pop_cnt - p0, 0);
            tx_cnt = 0;
        end

        // R8 timeout after tmo_limit wait cycles
        tmo_limit_i = 16'd5;
        ctl_we_i = 1; ctl_en_i = 1; ctl_dir_i = 1; bus_mode_i = 2'b00; ctl_len_i = 1;
        @(negedge clk_i);
        ctl_we_i = 0;
        for (int k = 1; k <= 6; k++) begin
            if (k > 1) @(negedge clk_i);
            chk(timeout_o == (k == 6), "R8 timeout timing", timeout_o, (k == 6));
        end
        @(negedge clk_i);

        // R9 underrun: length 2 but only one byte available
        begin
            int u0, d0;
            u0 = urun_cnt; d0 = done_cnt;
            txq[0] = 8'h42; tx_base = pop_cnt; tx_cnt = 1; dat_i = 8'hFF;
            ctl_we_i = 1; ctl_en_i = 1; ctl_dir_i = 0; bus_mode_i = 2'b10; ctl_len_i = 2;
            @(negedge clk_i);
            ctl_we_i = 0;
            repeat (6) @(negedge clk_i);
            chk(urun_cnt - u0 == 1, "R9 underrun flagged", urun_cnt - u0, 1);
            chk(dat_oe_o == 0 && done_cnt == d0, "R9 lines released no done", {dat_oe_o, 8'(done_cnt - d0)}, 0);
            tx_cnt = 0;
        end

        // R10 overrun: receive FIFO full when the byte completes
        begin
            int p0;
            p0 = push_cnt;
            rx_full_i = 1; dat_i = 8'hFF; tmo_limit_i = 16'd100;
            ctl_we_i = 1; ctl_en_i = 1; ctl_dir_i = 1; bus_mode_i = 2'b10; ctl_len_i = 1;
            @(negedge clk_i);
            ctl_we_i = 0;
            dat_i = 8'h00;
            @(negedge clk_i);
            dat_i = 8'h3C;
            @(negedge clk_i);
            dat_i = 8'hFF;
            chk(overrun_o == 1'b1, "R10 overrun flagged", overrun_o, 1);
            chk(push_cnt == p0, "R10 no push when full", push_cnt - p0, 0);
            rx_full_i = 0;
            repeat (3) @(negedge clk_i);
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule